// File: doc/BRIEF.md
# Supercolumn Row Serializer

This block sits at the edge of a pixel array and turns one row of counter data into a set of narrow, fast output streams. A row arrives as a single wide word in which every column supplies a 4-bit nibble. Adjacent columns are grouped eight at a time into supercolumns, and each supercolumn has its own output lane. In the fast mode, all lanes shift together at double data rate. Each clock carries two bits per lane: one for the rising half and one for the falling half.

For test access there is a slow mode. In this mode the whole row leaves on lane 0, one bit per clock, supercolumn by supercolumn. Counters deeper than 4 bits are sent as two or three successive nibble planes, lowest nibble first. A marker flags the first output beat of each row.

The input is a valid/ready stream. The source presents a plane with `in_valid` and must hold it, unchanged, until it sees `in_ready` high at a rising edge. Back-pressure comes only from the serializer: `in_ready` is low while a plane is being shifted out, except on its final beat. On that final beat a new plane can be taken with no idle cycle. The output side has no back-pressure, because the lanes model physical pins that cannot stall.

Top module: `sc_row_serializer`

## Requirements
- R1: `in_ready` is high when no plane is being shifted out, and also on the final beat of a plane. It is low on every other beat. A plane is taken on a rising edge with `in_valid` and `in_ready` both high, and its first beat appears with `out_valid` high in the next cycle.
- R2: In fast mode (`mode_slow` = 0 when the plane is taken), a plane occupies exactly 16 consecutive `out_valid` cycles on all 32 lanes.
- R3: Lane L carries columns 8L to 8L+7 in ascending column order. Within each nibble the most significant bit goes first. The nibble of column c is `in_data[4c+3:4c]`.
- R4: In fast mode, beat k carries stream bit 2k of each lane on `ddr_rise` and stream bit 2k+1 on `ddr_fall`.
- R5: In slow mode (`mode_slow` = 1 when the plane is taken), a plane occupies exactly 1024 beats. Beat k carries bit k mod 32 of supercolumn k/32 on `ddr_rise[0]`. All other `ddr_rise` bits and all `ddr_fall` bits are 0.
- R6: While `out_valid` is low, `ddr_rise` and `ddr_fall` are all zero.
- R7: `depth_sel` sets the number of planes per row: 0 gives 1 plane, 1 gives 2, 2 gives 3, and the reserved code 3 gives 1. `out_plane` numbers the plane currently shifting out, starting at 0. `row_start` is high only on the first beat of plane 0.
- R8: A plane taken on the final beat of the previous plane starts on the very next cycle, with no idle cycle between them.
- R9: `depth_sel` is sampled only when plane 0 of a row is taken. A change while later planes of the same row are loaded has no effect on that row.
- R10: After reset, `in_ready` is 1, and `out_valid`, `row_start`, `out_plane` and both lane buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both halves of the lane data are sampled per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A nibble plane is offered |
| in_ready | output | 1 | The serializer can take a plane this cycle |
| in_data | input | 1024 | Nibble plane; column c at bits 4c+3..4c |
| mode_slow | input | 1 | 1 = slow single-lane test mode, sampled when a plane is taken |
| depth_sel | input | 2 | Counter depth code, sampled when plane 0 is taken |
| out_valid | output | 1 | Lane buses carry a beat |
| row_start | output | 1 | First beat of a row |
| out_plane | output | 2 | Index of the plane being shifted out |
| ddr_rise | output | 32 | Rising-half bit of each lane |
| ddr_fall | output | 32 | Falling-half bit of each lane |

## Verification
The assertions assume the source obeys the handshake. A plane is offered only through `in_valid`, and a plane is counted as taken only when `in_valid` and `in_ready` are both high. The checker's beat counter, and the burst lengths it expects in each mode, depend on that rule. The bench drives its inputs on falling edges and raises `in_valid` only when it expects `in_ready` to be high. It drops `in_valid` one cycle after each transfer, so every plane is offered exactly once. The `mode_slow` and `depth_sel` values it applies are read only at the edge where a plane is taken.

// File: rtl/sc_ser_pkg.sv
package sc_ser_pkg;

  typedef enum logic [1:0] {
    DEPTH_4B  = 2'd0,
    DEPTH_8B  = 2'd1,
    DEPTH_12B = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  // Index of the final nibble plane for a given counter depth.
  function automatic logic [1:0] final_plane(input depth_e d);
    case (d)
      DEPTH_8B:  return 2'd1;
      DEPTH_12B: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sc_lane_bank.sv
module sc_lane_bank #(
  parameter int NLANES    = 32,
  parameter int LANE_BITS = 32,
  parameter int NIB       = 4,
  parameter int SEL_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NLANES*LANE_BITS-1:0] load_data,
  input  logic                        shift_pair,
  input  logic                        shift_single,
  input  logic [SEL_W-1:0]            sel,
  output logic [NLANES-1:0]           head_hi,
  output logic [NLANES-1:0]           head_lo
);
  localparam int COLS_PER_LANE = LANE_BITS / NIB;

  for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
    logic [LANE_BITS-1:0] img;
    logic [LANE_BITS-1:0] sr;

    // Column 0 of the lane lands in the top nibble so it leaves first.
    for (genvar cj = 0; cj < COLS_PER_LANE; cj++) begin : g_col
      assign img[LANE_BITS-1-NIB*cj -: NIB] =
        load_data[(ln*COLS_PER_LANE + cj)*NIB +: NIB];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sr <= '0;
      end else if (load) begin
        sr <= img;
      end else if (shift_pair) begin
        sr <= {sr[LANE_BITS-3:0], 2'b00};
      end else if (shift_single && (sel == SEL_W'(ln))) begin
        sr <= {sr[LANE_BITS-2:0], 1'b0};
      end
    end

    assign head_hi[ln] = sr[LANE_BITS-1];
    assign head_lo[ln] = sr[LANE_BITS-2];
  end

endmodule

// File: rtl/sc_ser_ctrl.sv
module sc_ser_ctrl
  import sc_ser_pkg::*;
#(
  parameter int FAST_BEATS = 16,
  parameter int SLOW_BEATS = 1024,
  parameter int CNT_W      = 10,
  parameter int LB_W       = 5,
  parameter int SEL_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             mode_slow,
  input  logic [1:0]       depth_sel,
  output logic             load,
  output logic             shift_pair,
  output logic             shift_single,
  output logic [SEL_W-1:0] sel,
  output logic             busy,
  output logic             slow_act,
  output logic             row_start,
  output logic [1:0]       out_plane
);
  logic [CNT_W-1:0] beat;
  logic [1:0]       plane_q;
  logic [1:0]       next_plane;
  logic [1:0]       last_q;
  logic [1:0]       last_new;
  logic             last_beat;

  assign last_beat = busy && (beat == (slow_act ? CNT_W'(SLOW_BEATS-1)
                                                : CNT_W'(FAST_BEATS-1)));
  assign in_ready  = !busy || last_beat;
  assign load      = in_valid && in_ready;
  assign last_new  = final_plane(depth_e'(depth_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      slow_act   <= 1'b0;
      beat       <= '0;
      plane_q    <= '0;
      next_plane <= '0;
      last_q     <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      beat     <= '0;
      slow_act <= mode_slow;
      plane_q  <= next_plane;
      if (next_plane == 2'd0) begin
        last_q     <= last_new;
        next_plane <= (last_new == 2'd0) ? 2'd0 : 2'd1;
      end else begin
        next_plane <= (next_plane == last_q) ? 2'd0 : next_plane + 2'd1;
      end
    end else if (busy) begin
      beat <= beat + 1'b1;
      if (last_beat) busy <= 1'b0;
    end
  end

  assign shift_pair   = busy && !slow_act;
  assign shift_single = busy && slow_act;
  assign sel          = beat[LB_W +: SEL_W];
  assign row_start    = busy && (beat == '0) && (plane_q == 2'd0);
  assign out_plane    = busy ? plane_q : 2'd0;

endmodule

// File: rtl/sc_out_map.sv
module sc_out_map #(
  parameter int NLANES = 32,
  parameter int SEL_W  = 5
) (
  input  logic              valid,
  input  logic              slow,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NLANES-1:0] head_hi,
  input  logic [NLANES-1:0] head_lo,
  output logic [NLANES-1:0] rise,
  output logic [NLANES-1:0] fall
);
  always_comb begin
    rise = '0;
    fall = '0;
    if (valid) begin
      if (slow) begin
        rise[0] = head_hi[sel];
      end else begin
        rise = head_hi;
        fall = head_lo;
      end
    end
  end
endmodule

// File: rtl/sc_row_serializer.sv
module sc_row_serializer #(
  parameter int NCOLS   = 256,
  parameter int NIB     = 4,
  parameter int SC_COLS = 8,
  localparam int NLANES     = NCOLS / SC_COLS,
  localparam int LANE_BITS  = SC_COLS * NIB,
  localparam int ROW_BITS   = NCOLS * NIB,
  localparam int FAST_BEATS = LANE_BITS / 2,
  localparam int CNT_W      = $clog2(ROW_BITS),
  localparam int LB_W       = $clog2(LANE_BITS),
  localparam int SEL_W      = $clog2(NLANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ROW_BITS-1:0] in_data,
  input  logic                mode_slow,
  input  logic [1:0]          depth_sel,
  output logic                out_valid,
  output logic                row_start,
  output logic [1:0]          out_plane,
  output logic [NLANES-1:0]   ddr_rise,
  output logic [NLANES-1:0]   ddr_fall
);
  logic              load, shift_pair, shift_single, slow_act;
  logic [SEL_W-1:0]  sel;
  logic [NLANES-1:0] head_hi, head_lo;

  sc_ser_ctrl #(
    .FAST_BEATS(FAST_BEATS), .SLOW_BEATS(ROW_BITS),
    .CNT_W(CNT_W), .LB_W(LB_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_slow(mode_slow), .depth_sel(depth_sel), .load(load),
    .shift_pair(shift_pair), .shift_single(shift_single), .sel(sel),
    .busy(out_valid), .slow_act(slow_act), .row_start(row_start),
    .out_plane(out_plane)
  );

  sc_lane_bank #(
    .NLANES(NLANES), .LANE_BITS(LANE_BITS), .NIB(NIB), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(in_data),
    .shift_pair(shift_pair), .shift_single(shift_single), .sel(sel),
    .head_hi(head_hi), .head_lo(head_lo)
  );

  sc_out_map #(.NLANES(NLANES), .SEL_W(SEL_W)) u_map (
    .valid(out_valid), .slow(slow_act), .sel(sel),
    .head_hi(head_hi), .head_lo(head_lo),
    .rise(ddr_rise), .fall(ddr_fall)
  );

endmodule

// File: rtl/sc_row_serializer_chk.sv
module sc_row_serializer_chk #(
  parameter int NLANES     = 32,
  parameter int FAST_BEATS = 16,
  parameter int SLOW_BEATS = 1024,
  parameter int CNT_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mode_slow,
  input logic              out_valid,
  input logic              row_start,
  input logic [NLANES-1:0] ddr_rise,
  input logic [NLANES-1:0] ddr_fall
);
  logic [CNT_W:0] k;
  logic           slow_seen;
  logic [CNT_W:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k         <= '0;
      slow_seen <= 1'b0;
    end else if (in_valid && in_ready) begin
      k         <= '0;
      slow_seen <= mode_slow;
    end else if (out_valid) begin
      k <= k + 1'b1;
    end
  end

  assign len = slow_seen ? (CNT_W+1)'(SLOW_BEATS) : (CNT_W+1)'(FAST_BEATS);

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1
  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1
  AST_MID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (k < len - 1'b1)) |-> !in_ready); // R1
  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (k < len - 1'b1)) |=> out_valid); // R2
  AST_LAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (k == len - 1'b1)) |-> in_ready); // R8
  AST_SLOW_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && slow_seen) |-> (ddr_fall == '0 && (ddr_rise >> 1) == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (ddr_rise == '0 && ddr_fall == '0)); // R6
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |-> (out_valid && k == '0)); // R7

endmodule

bind sc_row_serializer sc_row_serializer_chk #(
  .NLANES(NLANES), .FAST_BEATS(FAST_BEATS), .SLOW_BEATS(ROW_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mode_slow(mode_slow), .out_valid(out_valid), .row_start(row_start),
  .ddr_rise(ddr_rise), .ddr_fall(ddr_fall)
);

// File: tb/tb_sc_row_serializer.sv
`timescale 1ns/1ps
module tb_sc_row_serializer;
  localparam int NL = 32;
  localparam int RB = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [RB-1:0] in_data = '0;
  logic          mode_slow = 1'b0;
  logic [1:0]    depth_sel = 2'd0;
  logic          out_valid, row_start;
  logic [1:0]    out_plane;
  logic [NL-1:0] ddr_rise, ddr_fall;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_row_serializer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mode_slow(mode_slow), .depth_sel(depth_sel),
    .out_valid(out_valid), .row_start(row_start), .out_plane(out_plane),
    .ddr_rise(ddr_rise), .ddr_fall(ddr_fall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Stream bit idx of lane ln, derived from R3.
  function automatic logic sbit(input logic [RB-1:0] d, input int ln, input int idx);
    int col = 8*ln + idx/4;
    int b = 3 - idx%4;
    return d[4*col + b];
  endfunction

  function automatic logic [RB-1:0] pattern(input int seed);
    logic [RB-1:0] r;
    logic [31:0] s = 32'(seed) * 32'd2654435761 + 32'd12345;
    for (int w = 0; w < RB/32; w++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      r[32*w +: 32] = s;
    end
    return r;
  endfunction

  // Offer a plane on a falling edge; the transfer happens at the next rising edge.
  task automatic offer(input logic [RB-1:0] d, input bit slow, input logic [1:0] dsel);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready when idle", in_ready, 1);
    in_valid = 1'b1; in_data = d; mode_slow = slow; depth_sel = dsel;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Check one plane whose first beat is visible now. If chain is set, offer nd on its last beat.
  task automatic burst(input logic [RB-1:0] d, input bit slow, input bit exp_start,
                       input logic [1:0] exp_plane, input bit chain, input logic [RB-1:0] nd);
    int nb = slow ? RB : 16;
    int bad = 0;
    logic [NL-1:0] er, ef, ar, af;
    chk(row_start == exp_start, "R7", "row_start on first beat", row_start, exp_start);
    chk(out_plane == exp_plane, "R7", "plane index", out_plane, exp_plane);
    chk(in_ready == 1'b0, "R1", "ready low mid plane", in_ready, 0);
    for (int k = 0; k < nb; k++) begin
      er = '0; ef = '0;
      if (slow) er[0] = sbit(d, k/32, k%32);
      else for (int l = 0; l < NL; l++) begin
        er[l] = sbit(d, l, 2*k);
        ef[l] = sbit(d, l, 2*k+1);
      end
      if (!out_valid || ddr_rise != er || ddr_fall != ef || (k > 0 && row_start)) begin
        if (bad == 0) begin ar = ddr_rise; af = ddr_fall; end
        bad++;
      end
      if (k == nb-1 && chain) begin
        chk(in_ready == 1'b1, "R8", "ready on last beat", in_ready, 1);
        in_valid = 1'b1; in_data = nd; mode_slow = 1'b0; depth_sel = 2'd0;
      end
      if (bad == 1 && k == nb-1) begin end
      @(negedge clk);
    end
    if (slow) chk(bad == 0, "R5", "slow lane stream mismatches", bad, 0);
    else      chk(bad == 0, "R3 R4", "lane stream mismatches", bad, 0);
    if (chain) begin
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R8", "no gap between planes", out_valid, 1);
    end else begin
      chk(out_valid == 1'b0, slow ? "R5" : "R2", "plane length", out_valid, 0);
      chk(ddr_rise == '0 && ddr_fall == '0, "R6", "idle lanes quiet", ddr_rise | ddr_fall, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "reset ready", in_ready, 1);
    chk(out_valid == 1'b0 && row_start == 1'b0 && out_plane == 2'd0, "R10", "reset flags",
        {out_valid, row_start, out_plane}, 0);
    chk(ddr_rise == '0 && ddr_fall == '0, "R10", "reset lanes", ddr_rise | ddr_fall, 0);
  endtask

  task automatic t_fast_patterns();
    logic [RB-1:0] d;
    for (int c = 0; c < 256; c++) d[4*c +: 4] = 4'(c);
    offer(d, 1'b0, 2'd0); burst(d, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    d = '0; d[4*(8*5+3) + 2] = 1'b1;          // lone bit: lane 5, stream bit 13
    offer(d, 1'b0, 2'd0); burst(d, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    d = pattern(7);
    offer(d, 1'b0, 2'd0); burst(d, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    d = '1;
    offer(d, 1'b0, 2'd0); burst(d, 1'b0, 1'b1, 2'd0, 1'b0, '0);
  endtask

  task automatic t_slow();
    logic [RB-1:0] d = pattern(21);
    offer(d, 1'b1, 2'd0); burst(d, 1'b1, 1'b1, 2'd0, 1'b0, '0);
  endtask

  task automatic t_depth8_ignore_change();
    logic [RB-1:0] a = pattern(1), b = pattern(2), c = pattern(3);
    offer(a, 1'b0, 2'd1); burst(a, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    offer(b, 1'b0, 2'd2); burst(b, 1'b0, 1'b0, 2'd1, 1'b0, '0); // R9: depth change ignored
    offer(c, 1'b0, 2'd0); burst(c, 1'b0, 1'b1, 2'd0, 1'b0, '0);
  endtask

  task automatic t_depth12_mixed();
    logic [RB-1:0] a = pattern(4), b = pattern(5), c = pattern(6);
    offer(a, 1'b0, 2'd2); burst(a, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    offer(b, 1'b1, 2'd0); burst(b, 1'b1, 1'b0, 2'd1, 1'b0, '0); // R9 and slow plane inside a row
    offer(c, 1'b0, 2'd0); burst(c, 1'b0, 1'b0, 2'd2, 1'b0, '0);
    offer(a, 1'b0, 2'd0); burst(a, 1'b0, 1'b1, 2'd0, 1'b0, '0);
  endtask

  task automatic t_reserved_depth();
    logic [RB-1:0] a = pattern(8);
    offer(a, 1'b0, 2'd3); burst(a, 1'b0, 1'b1, 2'd0, 1'b0, '0);
    offer(a, 1'b0, 2'd3); burst(a, 1'b0, 1'b1, 2'd0, 1'b0, '0); // R7: code 3 gives 1 plane
  endtask

  task automatic t_back_to_back();
    logic [RB-1:0] a = pattern(11), b = pattern(12);
    offer(a, 1'b0, 2'd0);
    burst(a, 1'b0, 1'b1, 2'd0, 1'b1, b);
    burst(b, 1'b0, 1'b1, 2'd0, 1'b0, '0);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fast_patterns();
    t_slow();
    t_depth8_ignore_change();
    t_depth12_mixed();
    t_reserved_depth();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule